// File: doc/BRIEF.md
# Layer-3 Flow Shortcut Cache

This block sits beside a bridging switch that has an external router attached. It watches parsed frame headers and learns routed flows in two steps. A frame addressed to a known router MAC with no cached flow goes to the router, and a partial entry is opened for it. When the router sends the same flow back (source MAC is that router, same destination IP), the entry is completed. The block records the destination MAC the router wrote and the local output port. From then on, frames of that flow are switched locally with the stored rewrite fields. The router port is told to discard its buffered copy, so the router no longer carries the flow.

Router MACs are registered from the router's periodic hello frames, and only those MACs start flow handling. The flow key is the destination IP plus the router MAC. A path through two routers therefore holds one entry per hop. An entry that sees no traffic expires after a programmable number of timer ticks. Partial entries and complete entries each have their own limit. The block does not rewrite headers or regenerate CRCs; it only supplies the fields for that.

Top module: `flow_shortcut_cache`

## Requirements
- R1: Each frame presented with `frm_valid` produces exactly one decision with `dec_valid` high in the following cycle. Out of reset `dec_valid` and `flush_router` are 0.
- R2: A frame with `frm_fcs_ok` low is decided as drop (`dec_kind`=0). It neither creates nor completes any entry.
- R3: Only MACs learned from `hello_valid`/`hello_mac` count as routers. A frame whose destination MAC is not registered is decided as bridge (`dec_kind`=2), whatever its source MAC.
- R4: A good frame to a registered router MAC whose key (destination IP, router MAC) is absent, or only partial, is decided as to-router (`dec_kind`=1). The first such frame opens a partial entry.
- R5: A good frame whose source MAC is a registered router and whose key matches a partial entry completes that entry. It stores `frm_dst_mac` and `frm_out_port`. The frame itself is decided by its destination MAC.
- R6: A good frame hitting a complete entry is decided as shortcut (`dec_kind`=3). It outputs the stored destination MAC on `rw_dst_mac`, the router MAC on `rw_src_mac`, the stored port on `rw_port`, and `rw_dec_ttl`=1, with `flush_router`=1. `flush_router` is 0 on every other decision.
- R7: A partial entry whose return frame is never seen never yields a shortcut.
- R8: A partial entry survives `part_limit` ticks without a hit and is gone after the next tick.
- R9: A complete entry expires the same way under `full_limit`. Any hit restarts its idle count.
- R10: A flow crossing two routers uses a separate entry per router hop. A frame from the first router to the second both completes the first hop and is looked up against the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Ageing timer tick |
| part_limit | input | AGE_W | Idle ticks a partial entry survives |
| full_limit | input | AGE_W | Idle ticks a complete entry survives |
| hello_valid | input | 1 | Router hello seen |
| hello_mac | input | MAC_W | Router MAC carried by the hello |
| frm_valid | input | 1 | Parsed frame header present |
| frm_fcs_ok | input | 1 | Frame check sequence good |
| frm_src_mac | input | MAC_W | Frame source MAC |
| frm_dst_mac | input | MAC_W | Frame destination MAC |
| frm_dst_ip | input | IP_W | Frame destination IP |
| frm_out_port | input | PORT_W | Bridge output port for the destination MAC |
| dec_valid | output | 1 | Decision present |
| dec_kind | output | 2 | 0 drop, 1 to router, 2 bridge, 3 shortcut |
| rw_dst_mac | output | MAC_W | Rewrite destination MAC (shortcut only) |
| rw_src_mac | output | MAC_W | Rewrite source MAC, the router MAC (shortcut only) |
| rw_port | output | PORT_W | Shortcut output port |
| rw_dec_ttl | output | 1 | Decrement TTL on rewrite |
| flush_router | output | 1 | Router port discards its copy |

## Verification
The bench builds the block with 8 flow entries, 2 router slots, 4-bit age counters and 4-bit ports. It runs with a partial limit of 3 ticks and a complete limit of 5. The short limits put both expiry boundaries within a handful of ticks. The bench checks survival at exactly the limit and loss one tick later, for each entry kind. The eight entries hold every flow the sequence opens, including both hops of a two-router path. Every decision therefore depends on learning and ageing alone.

// File: rtl/flow_sc_pkg.sv
// Shared types for the flow shortcut cache.
package flow_sc_pkg;
    typedef enum logic [1:0] {
        DEC_DROP     = 2'd0,
        DEC_ROUTER   = 2'd1,
        DEC_BRIDGE   = 2'd2,
        DEC_SHORTCUT = 2'd3
    } dec_kind_t;
endpackage

// File: rtl/flow_rmac_list.sv
// Router MAC register list.
// Learns router MACs from hello frames, keeping no duplicates. A new MAC takes
// the first free slot; when all slots are full, a wrapping pointer picks the slot.
// Two probes answer, in the same cycle, whether a MAC is registered.
// Assumes a hello and a probe in the same cycle may see the old list.
module flow_rmac_list #(
    parameter int N     = 4,
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hello_valid,
    input  logic [MAC_W-1:0] hello_mac,
    input  logic [MAC_W-1:0] probe_a,
    input  logic [MAC_W-1:0] probe_b,
    output logic             hit_a,
    output logic             hit_b
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [MAC_W-1:0] mac_q [N];
    logic [N-1:0]     vld_q;
    logic [IW-1:0]    ptr_q;
    logic [N-1:0]     m_hello, m_a, m_b;
    logic             have_free;
    logic [IW-1:0]    free_idx;

    // Compare every slot against the hello and both probes; find a free slot.
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < N; i++) begin
            m_hello[i] = vld_q[i] && (mac_q[i] == hello_mac);
            m_a[i]     = vld_q[i] && (mac_q[i] == probe_a);
            m_b[i]     = vld_q[i] && (mac_q[i] == probe_b);
            if (!vld_q[i] && !have_free) begin
                have_free = 1'b1;
                free_idx  = IW'(i);
            end
        end
    end

    assign hit_a = |m_a;
    assign hit_b = |m_b;

    // Insert a hello MAC that is not yet on the list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
            for (int i = 0; i < N; i++) mac_q[i] <= '0;
        end else if (hello_valid && !(|m_hello)) begin
            if (have_free) begin
                vld_q[free_idx] <= 1'b1;
                mac_q[free_idx] <= hello_mac;
            end else begin
                mac_q[ptr_q] <= hello_mac;
                ptr_q        <= (ptr_q == IW'(N - 1)) ? '0 : ptr_q + IW'(1);
            end
        end
    end

    // A MAC is held at most once, so a hello never matches two slots.
    p_list_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_hello));
endmodule

// File: rtl/flow_table.sv
// Fully associative flow table with two-phase entries and idle ageing.
// Forward port: looks up (ip, router MAC). A hit restarts the entry's age; a miss
// opens a partial entry in the first free slot, or else in the oldest one.
// Return port: completes a matching partial entry with its rewrite fields.
// Ticks age every valid entry. An entry whose age has reached its limit (partial
// or complete) is removed on a tick. Assumes the two ports carry different keys.
module flow_table #(
    parameter int ENTRIES = 16,
    parameter int IP_W    = 32,
    parameter int MAC_W   = 48,
    parameter int PORT_W  = 6,
    parameter int AGE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [AGE_W-1:0]  part_limit,
    input  logic [AGE_W-1:0]  full_limit,
    input  logic              fwd_req,
    input  logic [IP_W-1:0]   fwd_ip,
    input  logic [MAC_W-1:0]  fwd_rmac,
    output logic              fwd_hit,
    output logic              fwd_full,
    output logic [MAC_W-1:0]  fwd_dst_mac,
    output logic [PORT_W-1:0] fwd_port,
    input  logic              ret_req,
    input  logic [IP_W-1:0]   ret_ip,
    input  logic [MAC_W-1:0]  ret_rmac,
    input  logic [MAC_W-1:0]  ret_dst_mac,
    input  logic [PORT_W-1:0] ret_port
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] valid_q, full_q;
    logic [IP_W-1:0]    ip_q   [ENTRIES];
    logic [MAC_W-1:0]   rmac_q [ENTRIES];
    logic [MAC_W-1:0]   dmac_q [ENTRIES];
    logic [PORT_W-1:0]  port_q [ENTRIES];
    logic [AGE_W-1:0]   age_q  [ENTRIES];

    logic [ENTRIES-1:0] fwd_m, ret_m;
    logic [IW-1:0]      fwd_idx, ret_idx, vict;
    logic               ret_hit, vict_found;
    logic [AGE_W-1:0]   best_age;

    // Match both keys against all entries and pick their indices.
    always_comb begin
        fwd_idx = '0;
        ret_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            fwd_m[i] = valid_q[i] && ip_q[i] == fwd_ip && rmac_q[i] == fwd_rmac;
            ret_m[i] = valid_q[i] && !full_q[i] && ip_q[i] == ret_ip && rmac_q[i] == ret_rmac;
            if (fwd_m[i]) fwd_idx = IW'(i);
            if (ret_m[i]) ret_idx = IW'(i);
        end
        fwd_hit     = |fwd_m;
        ret_hit     = |ret_m;
        fwd_full    = fwd_hit && full_q[fwd_idx];
        fwd_dst_mac = dmac_q[fwd_idx];
        fwd_port    = port_q[fwd_idx];
    end

    // Victim: first invalid slot, else the oldest, never the entry being completed.
    always_comb begin
        vict       = '0;
        vict_found = 1'b0;
        best_age   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_q[i] && !vict_found) begin
                vict       = IW'(i);
                vict_found = 1'b1;
            end
        end
        if (!vict_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!(ret_req && ret_hit && ret_idx == IW'(i)) &&
                    (!vict_found || age_q[i] > best_age)) begin
                    vict       = IW'(i);
                    vict_found = 1'b1;
                    best_age   = age_q[i];
                end
            end
        end
    end

    // Per-entry update: allocate, complete, refresh, expire or age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            full_q  <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ip_q[i]   <= '0;
                rmac_q[i] <= '0;
                dmac_q[i] <= '0;
                port_q[i] <= '0;
                age_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fwd_req && !fwd_hit && vict_found && vict == IW'(i)) begin
                    valid_q[i] <= 1'b1;
                    full_q[i]  <= 1'b0;
                    ip_q[i]    <= fwd_ip;
                    rmac_q[i]  <= fwd_rmac;
                    age_q[i]   <= '0;
                end else if (ret_req && ret_hit && ret_idx == IW'(i)) begin
                    full_q[i]  <= 1'b1;
                    dmac_q[i]  <= ret_dst_mac;
                    port_q[i]  <= ret_port;
                    age_q[i]   <= '0;
                end else if (fwd_req && fwd_hit && fwd_idx == IW'(i)) begin
                    age_q[i]   <= '0;
                end else if (tick && valid_q[i]) begin
                    if (age_q[i] >= (full_q[i] ? full_limit : part_limit)) begin
                        valid_q[i] <= 1'b0;
                        full_q[i]  <= 1'b0;
                    end else if (age_q[i] != '1) begin
                        age_q[i] <= age_q[i] + AGE_W'(1);
                    end
                end
            end
        end
    end

    // A key is never held twice.
    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fwd_m));

    // A completing return frame leaves its entry marked complete.
    p_ret_completes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && ret_hit) |=> full_q[$past(ret_idx)]);
endmodule

// File: rtl/flow_shortcut_cache.sv
// Layer-3 flow shortcut cache, top level.
// Decides each parsed frame as drop, to-router, bridge or shortcut, one cycle
// after it is presented, and learns flows from frames leaving and returning
// from registered routers. Assumes one header per cycle at most; the router
// list comes from hello frames.
module flow_shortcut_cache #(
    parameter int ENTRIES = 16,
    parameter int RMAC_N  = 4,
    parameter int IP_W    = 32,
    parameter int MAC_W   = 48,
    parameter int PORT_W  = 6,
    parameter int AGE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [AGE_W-1:0]  part_limit,
    input  logic [AGE_W-1:0]  full_limit,
    input  logic              hello_valid,
    input  logic [MAC_W-1:0]  hello_mac,
    input  logic              frm_valid,
    input  logic              frm_fcs_ok,
    input  logic [MAC_W-1:0]  frm_src_mac,
    input  logic [MAC_W-1:0]  frm_dst_mac,
    input  logic [IP_W-1:0]   frm_dst_ip,
    input  logic [PORT_W-1:0] frm_out_port,
    output logic              dec_valid,
    output logic [1:0]        dec_kind,
    output logic [MAC_W-1:0]  rw_dst_mac,
    output logic [MAC_W-1:0]  rw_src_mac,
    output logic [PORT_W-1:0] rw_port,
    output logic              rw_dec_ttl,
    output logic              flush_router
);
    import flow_sc_pkg::*;

    logic              dst_is_rtr, src_is_rtr, good, fwd_req, ret_req;
    logic              fwd_hit, fwd_full;
    logic [MAC_W-1:0]  fwd_dst_mac;
    logic [PORT_W-1:0] fwd_port;
    dec_kind_t         kind_d;

    flow_rmac_list #(.N(RMAC_N), .MAC_W(MAC_W)) u_rmac (
        .clk(clk), .rst_n(rst_n),
        .hello_valid(hello_valid), .hello_mac(hello_mac),
        .probe_a(frm_dst_mac), .probe_b(frm_src_mac),
        .hit_a(dst_is_rtr), .hit_b(src_is_rtr)
    );

    assign good    = frm_valid && frm_fcs_ok;
    assign fwd_req = good && dst_is_rtr;
    assign ret_req = good && src_is_rtr;

    flow_table #(.ENTRIES(ENTRIES), .IP_W(IP_W), .MAC_W(MAC_W),
                 .PORT_W(PORT_W), .AGE_W(AGE_W)) u_table (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .part_limit(part_limit), .full_limit(full_limit),
        .fwd_req(fwd_req), .fwd_ip(frm_dst_ip), .fwd_rmac(frm_dst_mac),
        .fwd_hit(fwd_hit), .fwd_full(fwd_full),
        .fwd_dst_mac(fwd_dst_mac), .fwd_port(fwd_port),
        .ret_req(ret_req), .ret_ip(frm_dst_ip), .ret_rmac(frm_src_mac),
        .ret_dst_mac(frm_dst_mac), .ret_port(frm_out_port)
    );

    // Classify the current frame.
    always_comb begin
        if (!frm_fcs_ok)               kind_d = DEC_DROP;
        else if (!dst_is_rtr)          kind_d = DEC_BRIDGE;
        else if (fwd_hit && fwd_full)  kind_d = DEC_SHORTCUT;
        else                           kind_d = DEC_ROUTER;
    end

    // Register the decision and, for shortcuts, the rewrite fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            dec_kind     <= DEC_DROP;
            rw_dst_mac   <= '0;
            rw_src_mac   <= '0;
            rw_port      <= '0;
            rw_dec_ttl   <= 1'b0;
            flush_router <= 1'b0;
        end else begin
            dec_valid    <= frm_valid;
            dec_kind     <= kind_d;
            if (frm_valid && kind_d == DEC_SHORTCUT) begin
                rw_dst_mac   <= fwd_dst_mac;
                rw_src_mac   <= frm_dst_mac;
                rw_port      <= fwd_port;
                rw_dec_ttl   <= 1'b1;
                flush_router <= 1'b1;
            end else begin
                rw_dst_mac   <= '0;
                rw_src_mac   <= '0;
                rw_port      <= '0;
                rw_dec_ttl   <= 1'b0;
                flush_router <= 1'b0;
            end
        end
    end

    // One decision per frame, in the next cycle.
    p_one_decision_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> dec_valid);
    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !dec_valid);
    // Bad FCS always drops.
    p_fcs_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_fcs_ok) |=> (dec_kind == DEC_DROP));
    // Flush only accompanies a shortcut.
    p_flush_only_shortcut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_router |-> (dec_valid && dec_kind == DEC_SHORTCUT));
    // The new source MAC is the router the frame was addressed to.
    p_rw_src_router_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && kind_d == DEC_SHORTCUT) |=> (rw_src_mac == $past(frm_dst_mac)));
endmodule

// File: tb/test_flow_shortcut_cache.sv
module test_flow_shortcut_cache;
    localparam int MW = 48;
    localparam int PW = 4;
    localparam int AW = 4;

    typedef struct packed {
        logic [1:0]    kind;
        logic [MW-1:0] dmac;
        logic [MW-1:0] smac;
        logic [PW-1:0] port;
        logic          ttl;
        logic          flush;
    } exp_t;

    localparam logic [MW-1:0] R1 = 48'h0200_0000_0011;
    localparam logic [MW-1:0] R2 = 48'h0200_0000_0022;
    localparam logic [MW-1:0] NR = 48'h0200_0000_0033;
    localparam logic [MW-1:0] H1 = 48'h0400_0000_00a1;
    localparam logic [MW-1:0] H2 = 48'h0400_0000_00a2;
    localparam logic [MW-1:0] H3 = 48'h0400_0000_00a3;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic hello_valid = 1'b0, frm_valid = 1'b0, frm_fcs_ok = 1'b1;
    logic [MW-1:0] hello_mac = '0, frm_src_mac = '0, frm_dst_mac = '0;
    logic [31:0]   frm_dst_ip = '0;
    logic [PW-1:0] frm_out_port = '0;
    logic dec_valid, rw_dec_ttl, flush_router;
    logic [1:0] dec_kind;
    logic [MW-1:0] rw_dst_mac, rw_src_mac;
    logic [PW-1:0] rw_port;

    int checks = 0, errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    flow_shortcut_cache #(.ENTRIES(8), .RMAC_N(2), .IP_W(32), .MAC_W(MW),
                          .PORT_W(PW), .AGE_W(AW)) i_flow_shortcut_cache (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .part_limit(4'd3), .full_limit(4'd5),
        .hello_valid(hello_valid), .hello_mac(hello_mac),
        .frm_valid(frm_valid), .frm_fcs_ok(frm_fcs_ok),
        .frm_src_mac(frm_src_mac), .frm_dst_mac(frm_dst_mac),
        .frm_dst_ip(frm_dst_ip), .frm_out_port(frm_out_port),
        .dec_valid(dec_valid), .dec_kind(dec_kind),
        .rw_dst_mac(rw_dst_mac), .rw_src_mac(rw_src_mac),
        .rw_port(rw_port), .rw_dec_ttl(rw_dec_ttl), .flush_router(flush_router)
    );

    // Driver: present one frame for a cycle and queue its expected decision.
    task automatic send(input logic fcs, input logic [MW-1:0] s, input logic [MW-1:0] d,
                        input logic [31:0] ip, input logic [PW-1:0] op,
                        input logic [1:0] k, input logic [MW-1:0] ed,
                        input logic [PW-1:0] ep, input string tag);
        exp_t e;
        @(negedge clk);
        frm_valid = 1'b1; frm_fcs_ok = fcs; frm_src_mac = s; frm_dst_mac = d;
        frm_dst_ip = ip; frm_out_port = op;
        e.kind = k;
        e.dmac = (k == 2'd3) ? ed : '0;
        e.smac = (k == 2'd3) ? d : '0;
        e.port = (k == 2'd3) ? ep : '0;
        e.ttl  = (k == 2'd3);
        e.flush = (k == 2'd3);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        frm_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic hello(input logic [MW-1:0] m);
        @(negedge clk);
        hello_valid = 1'b1; hello_mac = m;
        @(negedge clk);
        hello_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    // Monitor: compare every decision with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            exp_t e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected decision kind=%0d expected none", dec_kind);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({dec_kind, rw_dst_mac, rw_src_mac, rw_port, rw_dec_ttl, flush_router} !== e) begin
                    errors++;
                    $display("FAIL %s actual kind=%0d dmac=%h smac=%h port=%0d ttl=%0b flush=%0b expected kind=%0d dmac=%h smac=%h port=%0d ttl=%0b flush=%0b",
                             t, dec_kind, rw_dst_mac, rw_src_mac, rw_port, rw_dec_ttl, flush_router,
                             e.kind, e.dmac, e.smac, e.port, e.ttl, e.flush);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dec_valid !== 1'b0 || flush_router !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state valid=%b flush=%b expected 0 0", dec_valid, flush_router);
        end
        // R3: router not yet registered, so bridge.
        send(1, H1, R1, 32'h0a00_0001, 0, 2'd2, '0, 0, "R3");
        hello(R1); hello(R2); hello(R1);
        // R2: bad FCS drops and does not complete the partial entry.
        send(1, H1, R1, 32'h0a00_0001, 0, 2'd1, '0, 0, "R4");
        send(0, R1, H2, 32'h0a00_0001, 3, 2'd0, '0, 0, "R2");
        send(0, H1, R1, 32'h0a00_0001, 0, 2'd0, '0, 0, "R2");
        send(1, H1, R1, 32'h0a00_0001, 0, 2'd1, '0, 0, "R2");
        // R3: ordinary bridged frame and an unregistered source.
        send(1, H1, H2, 32'h0a00_0005, 0, 2'd2, '0, 0, "R3");
        send(1, H1, R1, 32'h0a00_0020, 0, 2'd1, '0, 0, "R7");
        send(1, NR, H2, 32'h0a00_0020, 4, 2'd2, '0, 0, "R3");
        send(1, H1, R1, 32'h0a00_0020, 0, 2'd1, '0, 0, "R7");
        // R4, R5, R6: learn and use a shortcut.
        send(1, H1, R1, 32'h0a00_0010, 0, 2'd1, '0, 0, "R4");
        send(1, H1, R1, 32'h0a00_0010, 0, 2'd1, '0, 0, "R4");
        send(1, R1, H2, 32'h0a00_0010, 5, 2'd2, '0, 0, "R5");
        send(1, H1, R1, 32'h0a00_0010, 0, 2'd3, H2, 5, "R6");
        // R10: two router hops.
        send(1, H1, R1, 32'h0a00_0030, 0, 2'd1, '0, 0, "R10");
        send(1, R1, R2, 32'h0a00_0030, 2, 2'd1, '0, 0, "R10");
        send(1, R2, H3, 32'h0a00_0030, 7, 2'd2, '0, 0, "R10");
        send(1, H1, R1, 32'h0a00_0030, 0, 2'd3, R2, 2, "R10");
        send(1, R1, R2, 32'h0a00_0030, 0, 2'd3, H3, 7, "R10");
        // R8: partial survives exactly its limit.
        send(1, H1, R1, 32'h0a00_0040, 0, 2'd1, '0, 0, "R8");
        ticks(3);
        send(1, R1, H2, 32'h0a00_0040, 9, 2'd2, '0, 0, "R8");
        send(1, H1, R1, 32'h0a00_0040, 0, 2'd3, H2, 9, "R8");
        // R8, R7: one more tick removes the unanswered partial.
        ticks(1);
        send(1, R1, H2, 32'h0a00_0020, 4, 2'd2, '0, 0, "R8");
        send(1, H1, R1, 32'h0a00_0020, 0, 2'd1, '0, 0, "R7");
        // R9: complete entry at idle 4 of 5 still hits and refreshes.
        send(1, H1, R1, 32'h0a00_0010, 0, 2'd3, H2, 5, "R9");
        ticks(2);
        send(1, H1, R1, 32'h0a00_0030, 0, 2'd1, '0, 0, "R9");
        send(1, H1, R1, 32'h0a00_0010, 0, 2'd3, H2, 5, "R9");
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing decisions actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule